// File: doc/BRIEF.md
# Display Auxiliary Channel Transaction Controller

This block runs one request/reply exchange on a display side channel. Software fills five 32-bit data words with up to twenty request bytes and then writes a control word. That write sets the request length, the reply timeout, the interrupt enable and the bit-clock divider, and it starts the exchange. The controller sends the request bytes to a transmit byte stream that uses a valid/ready handshake. It then collects reply bytes from a receive stream into the same data words. At the end it reports the outcome in sticky status bits and returns the reply length in the length field.

A free-running divider makes a tick at twice the channel bit rate. Every second tick marks one microsecond, and the reply timeout is counted in these microsecond marks. Line coding and the analog driver are outside the block. The receive side presents plain bytes, a framing-error strobe and an end-of-packet strobe.

Top module: `aux_xact_ctrl`

## Requirements
- R1: After reset the control word reads 0 (address 0), `tx_valid` is 0 and `irq` is 0.
- R2: A control write while idle loads interrupt enable (bit 29), timeout select (bits 27:26), length (bits 24:20), precharge (bits 19:16) and divider (bits 10:0), and these read back at the same positions. Writing 1 to done (bit 30), timeout error (bit 28) or receive error (bit 25) clears that bit, including in the write that starts an exchange.
- R3: Writing bit 31 as 1 while idle sets busy (bit 31) and sends the request bytes in order on `tx_data`. Byte k comes from data word 1+k/4 (addresses 1 to 5), bits 31-8*(k%4) down to 24-8*(k%4). Each byte is held until `tx_ready` accepts it.
- R4: Reply bytes are written into the data words with the same layout. On `rx_eop` busy clears, done sets, and bits 24:20 hold the number of reply bytes.
- R5: If no reply byte arrives within the window chosen by bits 27:26 (0: 400, 1: 600, 2: 800, 3: 1600 microseconds, one microsecond being two divider ticks), the timeout error and done set and busy clears.
- R6: `rx_ferr` ends the exchange with the receive error and done set. A byte presented in the same cycle is not stored.
- R7: A twenty-first reply byte ends the exchange with the receive error set and the count held at 20.
- R8: An end-of-packet with zero reply bytes sets the receive error.
- R9: `irq` goes to 1 one cycle after done is set while interrupt enable is 1.
- R10: `bit_tick` pulses once every D clocks, where D is the divider field, and a divider of 0 acts as 1.
- R11: While busy, writes to the control word and to the data words have no effect.
- R12: A reply byte that arrives in the same cycle as `rx_eop` is stored and counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address: 0 control, 1..5 data |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Read data, valid one cycle after rd_en |
| tx_valid | output | 1 | Request byte valid |
| tx_ready | input | 1 | Transmit side accepts the byte |
| tx_data | output | 8 | Request byte |
| rx_valid | input | 1 | Reply byte valid |
| rx_data | input | 8 | Reply byte |
| rx_eop | input | 1 | End of reply packet |
| rx_ferr | input | 1 | Receive framing error |
| bit_tick | output | 1 | Twice-bit-rate tick |
| irq | output | 1 | Completion interrupt |

## Verification
Two pairs of receive events can fall in the same cycle. The bench drives the last reply byte together with `rx_eop` in some table rows, and judges the result by a length field that includes that byte and by the byte appearing in its data word. It also drives a byte together with `rx_ferr`, and judges the result by the receive error being set while the data word keeps its request contents. A start write that also clears done is checked by reading busy set and done clear while the transmit side is stalled.

// File: rtl/aux_ctl_pkg.sv
package aux_ctl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_RECV = 2'd2
  } eng_state_e;

  // Reply window in microseconds for each timeout select code
  function automatic logic [10:0] window_us(input logic [1:0] sel);
    case (sel)
      2'd0:    return 11'd400;
      2'd1:    return 11'd600;
      2'd2:    return 11'd800;
      default: return 11'd1600;
    endcase
  endfunction

endpackage

// File: rtl/aux_tick_gen.sv
module aux_tick_gen #(
  parameter int DIV_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             bit_tick,
  output logic             us_tick
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim;
  logic             phase_q;
  logic             bit_q;
  logic             us_q;

  assign lim = (div == '0) ? DIV_W'(1) : div;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
      bit_q   <= 1'b0;
      us_q    <= 1'b0;
    end else if (cnt_q >= lim - DIV_W'(1)) begin
      cnt_q   <= '0;
      bit_q   <= 1'b1;
      phase_q <= ~phase_q;
      us_q    <= phase_q;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
      bit_q <= 1'b0;
      us_q  <= 1'b0;
    end
  end

  assign bit_tick = bit_q;
  assign us_tick  = us_q;

  assert_us_on_bit_R10: assert property (@(posedge clk) disable iff (rst)
    us_q |-> bit_q);

endmodule

// File: rtl/aux_data_store.sv
module aux_data_store #(
  parameter int NUM_WORDS = 5,
  parameter int CNT_W     = 5,
  localparam int WI_W     = $clog2(NUM_WORDS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_we,
  input  logic [WI_W-1:0] bus_widx,
  input  logic [31:0]     bus_wdata,
  input  logic            eng_we,
  input  logic [CNT_W-1:0] eng_widx,
  input  logic [7:0]      eng_wbyte,
  input  logic [CNT_W-1:0] eng_ridx,
  output logic [7:0]      eng_rbyte,
  input  logic [WI_W-1:0] rd_widx,
  output logic [31:0]     rd_word
);
  logic [31:0] words [NUM_WORDS];
  logic [WI_W-1:0] ew, erw;
  logic [1:0]      el, erl;
  logic [31:0]     eword;

  assign ew  = eng_widx[WI_W+1:2];
  assign el  = eng_widx[1:0];
  assign erw = eng_ridx[WI_W+1:2];
  assign erl = eng_ridx[1:0];

  // Byte-lane writes, earliest byte in the top lane
  always_ff @(posedge clk) begin
    if (eng_we) begin
      case (el)
        2'd0:    words[ew][31:24] <= eng_wbyte;
        2'd1:    words[ew][23:16] <= eng_wbyte;
        2'd2:    words[ew][15:8]  <= eng_wbyte;
        default: words[ew][7:0]   <= eng_wbyte;
      endcase
    end else if (bus_we) begin
      words[bus_widx] <= bus_wdata;
    end
  end

  assign eword   = words[erw];
  assign rd_word = words[rd_widx];

  always_comb begin
    case (erl)
      2'd0:    eng_rbyte = eword[31:24];
      2'd1:    eng_rbyte = eword[23:16];
      2'd2:    eng_rbyte = eword[15:8];
      default: eng_rbyte = eword[7:0];
    endcase
  end

  assert_single_writer_R11: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && eng_we));

endmodule

// File: rtl/aux_engine.sv
module aux_engine
  import aux_ctl_pkg::*;
#(
  parameter int MAX_BYTES = 20,
  parameter int CNT_W     = 5,
  parameter int DIV_W     = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_we,
  input  logic [31:0]      ctl_wdata,
  input  logic             us_tick,
  input  logic             tx_ready,
  output logic             tx_valid,
  output logic [7:0]       tx_data,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  input  logic             rx_eop,
  input  logic             rx_ferr,
  output logic [CNT_W-1:0] rd_idx,
  input  logic [7:0]       rd_byte,
  output logic             wr_en,
  output logic [CNT_W-1:0] wr_idx,
  output logic [7:0]       wr_byte,
  output logic [31:0]      ctl_word,
  output logic [DIV_W-1:0] div,
  output logic             busy,
  output logic             irq
);
  eng_state_e       state_q;
  logic             busy_q, done_q, ie_q, terr_q, rerr_q;
  logic [1:0]       tsel_q;
  logic [4:0]       size_q;
  logic [3:0]       pre_q;
  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] idx_q, cnt_q, n_rx;
  logic [10:0]      tcnt_q;
  logic             got_q, tx_valid_q, irq_q;
  logic [7:0]       tx_data_q;
  logic             hs, rx_over, timeout_hit;
  logic [4:0]       wlen, len_eff;
  logic             unused_bits;

  assign unused_bits = ^ctl_wdata[15:11];
  assign hs          = tx_valid_q & tx_ready;
  assign rd_idx      = hs ? idx_q + CNT_W'(1) : '0;
  assign n_rx        = cnt_q + CNT_W'(rx_valid);
  assign rx_over     = rx_valid && (cnt_q == CNT_W'(MAX_BYTES));
  assign wr_en       = (state_q == ST_RECV) && !rx_ferr && rx_valid && !rx_over;
  assign wr_idx      = cnt_q;
  assign wr_byte     = rx_data;
  assign timeout_hit = (state_q == ST_RECV) && !got_q && !rx_valid && !rx_eop &&
                       !rx_ferr && us_tick && (tcnt_q == window_us(tsel_q) - 11'd1);

  always_comb begin
    wlen = ctl_wdata[24:20];
    if (wlen == 5'd0)                 len_eff = 5'd1;
    else if (wlen > 5'(MAX_BYTES))    len_eff = 5'(MAX_BYTES);
    else                              len_eff = wlen;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      busy_q <= 1'b0; done_q <= 1'b0; ie_q <= 1'b0; terr_q <= 1'b0; rerr_q <= 1'b0;
      tsel_q <= '0; size_q <= '0; pre_q <= '0; div_q <= '0;
      idx_q <= '0; cnt_q <= '0; tcnt_q <= '0; got_q <= 1'b0;
      tx_valid_q <= 1'b0; tx_data_q <= '0; irq_q <= 1'b0;
    end else begin
      irq_q <= done_q & ie_q;
      case (state_q)
        ST_IDLE: if (ctl_we) begin
          ie_q   <= ctl_wdata[29];
          tsel_q <= ctl_wdata[27:26];
          size_q <= len_eff;
          pre_q  <= ctl_wdata[19:16];
          div_q  <= ctl_wdata[DIV_W-1:0];
          if (ctl_wdata[30]) done_q <= 1'b0;
          if (ctl_wdata[28]) terr_q <= 1'b0;
          if (ctl_wdata[25]) rerr_q <= 1'b0;
          if (ctl_wdata[31]) begin
            busy_q     <= 1'b1;
            state_q    <= ST_SEND;
            idx_q      <= '0;
            cnt_q      <= '0;
            tcnt_q     <= '0;
            got_q      <= 1'b0;
            tx_valid_q <= 1'b1;
            tx_data_q  <= rd_byte;
          end
        end
        ST_SEND: if (hs) begin
          if (idx_q + CNT_W'(1) == CNT_W'(size_q)) begin
            tx_valid_q <= 1'b0;
            state_q    <= ST_RECV;
          end else begin
            idx_q     <= idx_q + CNT_W'(1);
            tx_data_q <= rd_byte;
          end
        end
        ST_RECV: begin
          if (rx_ferr || rx_over) begin
            rerr_q <= 1'b1; size_q <= 5'(cnt_q);
            busy_q <= 1'b0; done_q <= 1'b1; state_q <= ST_IDLE;
          end else begin
            if (rx_valid) begin
              cnt_q <= n_rx;
              got_q <= 1'b1;
            end
            if (rx_eop) begin
              size_q <= 5'(n_rx);
              if (n_rx == '0) rerr_q <= 1'b1;
              busy_q <= 1'b0; done_q <= 1'b1; state_q <= ST_IDLE;
            end else if (timeout_hit) begin
              terr_q <= 1'b1; size_q <= 5'(cnt_q);
              busy_q <= 1'b0; done_q <= 1'b1; state_q <= ST_IDLE;
            end else if (us_tick && !got_q && !rx_valid) begin
              tcnt_q <= tcnt_q + 11'd1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ctl_word = {busy_q, done_q, ie_q, terr_q, tsel_q, rerr_q, size_q, pre_q,
                     5'b0, div_q};
  assign tx_valid = tx_valid_q;
  assign tx_data  = tx_data_q;
  assign div      = div_q;
  assign busy     = busy_q;
  assign irq      = irq_q;

  assert_tx_hold_R3: assert property (@(posedge clk) disable iff (rst)
    tx_valid_q && !tx_ready |=> tx_valid_q && $stable(tx_data_q));
  assert_tx_in_busy_R3: assert property (@(posedge clk) disable iff (rst)
    tx_valid_q |-> busy_q);
  assert_count_bound_R7: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(MAX_BYTES));
  assert_busy_write_ignored_R11: assert property (@(posedge clk) disable iff (rst)
    busy_q && ctl_we |=> $stable(tsel_q) && $stable(div_q) && $stable(ie_q));

endmodule

// File: rtl/aux_xact_ctrl.sv
module aux_xact_ctrl #(
  parameter int NUM_WORDS = 5,
  localparam int MAX_BYTES = 4 * NUM_WORDS,
  localparam int CNT_W     = $clog2(MAX_BYTES + 1),
  localparam int WI_W      = $clog2(NUM_WORDS),
  localparam int AW        = $clog2(NUM_WORDS + 1),
  localparam int DIV_W     = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [31:0]   rd_data,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_data,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          rx_eop,
  input  logic          rx_ferr,
  output logic          bit_tick,
  output logic          irq
);
  logic             ctl_we, bus_we, busy, us_tick;
  logic [WI_W-1:0]  bus_widx, rd_widx;
  logic [CNT_W-1:0] e_ridx, e_widx;
  logic [7:0]       e_rbyte, e_wbyte;
  logic             e_we;
  logic [31:0]      ctl_word, rd_word, rd_q;
  logic [DIV_W-1:0] div;

  assign ctl_we   = wr_en && (wr_addr == '0);
  assign bus_we   = wr_en && (wr_addr != '0) && (wr_addr <= AW'(NUM_WORDS)) && !busy;
  assign bus_widx = WI_W'(wr_addr - AW'(1));
  assign rd_widx  = WI_W'(rd_addr - AW'(1));

  aux_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .div(div), .bit_tick(bit_tick), .us_tick(us_tick)
  );

  aux_data_store #(.NUM_WORDS(NUM_WORDS), .CNT_W(CNT_W)) u_store (
    .clk(clk), .rst(rst),
    .bus_we(bus_we), .bus_widx(bus_widx), .bus_wdata(wr_data),
    .eng_we(e_we), .eng_widx(e_widx), .eng_wbyte(e_wbyte),
    .eng_ridx(e_ridx), .eng_rbyte(e_rbyte),
    .rd_widx(rd_widx), .rd_word(rd_word)
  );

  aux_engine #(.MAX_BYTES(MAX_BYTES), .CNT_W(CNT_W), .DIV_W(DIV_W)) u_engine (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(wr_data), .us_tick(us_tick),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_eop(rx_eop), .rx_ferr(rx_ferr),
    .rd_idx(e_ridx), .rd_byte(e_rbyte),
    .wr_en(e_we), .wr_idx(e_widx), .wr_byte(e_wbyte),
    .ctl_word(ctl_word), .div(div), .busy(busy), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else if (rd_en) begin
      if (rd_addr == '0)                   rd_q <= ctl_word;
      else if (rd_addr <= AW'(NUM_WORDS))  rd_q <= rd_word;
      else                                 rd_q <= '0;
    end
  end

  assign rd_data = rd_q;

endmodule

// File: tb/aux_xact_ctrl_tb.sv
module aux_xact_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst;
  logic        wr_en, rd_en;
  logic [2:0]  wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  logic        tx_valid, tx_ready;
  logic [7:0]  tx_data;
  logic        rx_valid, rx_eop, rx_ferr;
  logic [7:0]  rx_data;
  logic        bit_tick, irq;

  aux_xact_ctrl u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_eop(rx_eop), .rx_ferr(rx_ferr),
    .bit_tick(bit_tick), .irq(irq)
  );

  typedef struct packed {
    logic [4:0] req;
    logic [4:0] rep;
    logic       joint;
  } vec_t;

  localparam vec_t VEC [4] = '{
    '{5'd4,  5'd4,  1'b0},
    '{5'd20, 5'd20, 1'b1},
    '{5'd1,  5'd7,  1'b0},
    '{5'd13, 5'd1,  1'b1}
  };

  int checks = 0, errors = 0, cyc = 0;
  logic [7:0]  mdl [20];
  logic [31:0] d;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected<150000 cycles", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ctlw(bit busy, bit done, bit ie, bit terr,
      logic [1:0] tsel, bit rerr, logic [4:0] size, logic [3:0] pre, logic [10:0] dv);
    return {busy, done, ie, terr, tsel, rerr, size, pre, 5'b0, dv};
  endfunction

  task automatic bus_wr(logic [2:0] a, logic [31:0] v);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(logic [2:0] a, output logic [31:0] v);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    @(negedge clk); rd_en = 1'b0; v = rd_data;
  endtask

  task automatic expect_tx(int len, string tag);
    int k = 0;
    while (k < len) begin
      if (tx_valid === 1'b1) begin
        chk(tag, {24'd0, tx_data}, {24'd0, mdl[k]});
        k++;
      end
      @(negedge clk);
    end
  endtask

  task automatic rx_beat(logic [7:0] b, logic eop, logic ferr);
    rx_valid = 1'b1; rx_data = b; rx_eop = eop; rx_ferr = ferr;
    @(negedge clk);
    rx_valid = 1'b0; rx_eop = 1'b0; rx_ferr = 1'b0;
  endtask

  task automatic rx_eop_only();
    rx_eop = 1'b1;
    @(negedge clk);
    rx_eop = 1'b0;
  endtask

  task automatic tick_period(logic [10:0] dv, int exp, string tag);
    int n = 0;
    bus_wr(3'd0, ctlw(0, 0, 0, 0, 2'd0, 0, 5'd1, 4'h0, dv));
    repeat (12) @(negedge clk);
    while (bit_tick !== 1'b1) @(negedge clk);
    @(negedge clk); n = 1;
    while (bit_tick !== 1'b1) begin @(negedge clk); n++; end
    chk(tag, n, exp);
  endtask

  task automatic timeout_run(logic [1:0] sel, int lo, int hi);
    int n = 0;
    bus_wr(3'd0, ctlw(1, 1, 1, 1, sel, 1, 5'd1, 4'h9, 11'd2));
    @(negedge clk); n = 1;
    while (irq !== 1'b1) begin @(negedge clk); n++; end
    checks++;
    if (n < lo || n > hi) begin
      errors++;
      $display("FAIL R5 timeout cycles actual=%0d expected=%0d..%0d", n, lo, hi);
    end
    bus_rd(3'd0, d);
    chk("R5 timeout status", d, ctlw(0, 1, 1, 1, sel, 0, 5'd0, 4'h9, 11'd2));
  endtask

  initial begin
    rst = 1'b1; wr_en = 0; rd_en = 0; wr_addr = 0; rd_addr = 0; wr_data = 0;
    tx_ready = 1'b1; rx_valid = 0; rx_data = 0; rx_eop = 0; rx_ferr = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    bus_rd(3'd0, d);
    chk("R1 control", d, 32'd0);
    chk("R1 tx_valid", {31'd0, tx_valid}, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);

    // R2 field readback
    bus_wr(3'd0, ctlw(0, 0, 1, 0, 2'd3, 0, 5'd7, 4'hA, 11'd2));
    bus_rd(3'd0, d);
    chk("R2 readback", d, ctlw(0, 0, 1, 0, 2'd3, 0, 5'd7, 4'hA, 11'd2));

    // R10 divider tick spacing
    tick_period(11'd2, 2, "R10 div2");
    tick_period(11'd5, 5, "R10 div5");
    tick_period(11'd0, 1, "R10 div0");

    // Table of transactions: R3 R4 R9 R12
    for (int v = 0; v < 4; v++) begin
      for (int k = 0; k < 20; k++) mdl[k] = 8'(v * 32 + k + 1);
      for (int w = 0; w < 5; w++)
        bus_wr(3'(w + 1), {mdl[4*w], mdl[4*w+1], mdl[4*w+2], mdl[4*w+3]});
      bus_wr(3'd0, ctlw(1, 1, 1, 1, 2'd0, 1, VEC[v].req, 4'h9, 11'd2));
      expect_tx(int'(VEC[v].req), "R3 tx byte");
      for (int j = 0; j < int'(VEC[v].rep); j++) begin
        mdl[j] = 8'(8'hC0 ^ (j * 3 + v));
        rx_beat(mdl[j], VEC[v].joint && (j == int'(VEC[v].rep) - 1), 1'b0);
      end
      if (!VEC[v].joint) rx_eop_only();
      bus_rd(3'd0, d);
      if (VEC[v].joint) chk("R12 status", d, ctlw(0, 1, 1, 0, 2'd0, 0, VEC[v].rep, 4'h9, 11'd2));
      else              chk("R4 status",  d, ctlw(0, 1, 1, 0, 2'd0, 0, VEC[v].rep, 4'h9, 11'd2));
      chk("R9 irq", {31'd0, irq}, 32'd1);
      for (int w = 0; w < 5; w++) begin
        bus_rd(3'(w + 1), d);
        chk("R4 reply word", d, {mdl[4*w], mdl[4*w+1], mdl[4*w+2], mdl[4*w+3]});
      end
    end

    // R2 write-one-to-clear without start
    bus_wr(3'd0, ctlw(0, 1, 1, 1, 2'd0, 1, 5'd4, 4'h9, 11'd2));
    bus_rd(3'd0, d);
    chk("R2 clear done", d, ctlw(0, 0, 1, 0, 2'd0, 0, 5'd4, 4'h9, 11'd2));

    // R11 writes during busy ignored; R2 start write clears done
    bus_wr(3'd1, 32'h0A0B0C0D);
    mdl[0] = 8'h0A; mdl[1] = 8'h0B;
    bus_wr(3'd0, ctlw(0, 0, 1, 0, 2'd0, 0, 5'd4, 4'h9, 11'd2));
    tx_ready = 1'b0;
    bus_wr(3'd0, ctlw(1, 1, 1, 1, 2'd0, 1, 5'd2, 4'h9, 11'd2));
    bus_wr(3'd1, 32'hFFFFFFFF);
    bus_wr(3'd0, ctlw(1, 1, 0, 1, 2'd3, 1, 5'd5, 4'h0, 11'd7));
    bus_rd(3'd0, d);
    chk("R11 control while busy", d, ctlw(1, 0, 1, 0, 2'd0, 0, 5'd2, 4'h9, 11'd2));
    tx_ready = 1'b1;
    expect_tx(2, "R11 tx bytes");
    rx_beat(8'h55, 1'b1, 1'b0);
    bus_rd(3'd1, d);
    chk("R11 data word", d, 32'h550B0C0D);

    // R6 framing error with a byte in the same cycle
    bus_wr(3'd1, 32'h11223344);
    mdl[0] = 8'h11;
    bus_wr(3'd0, ctlw(1, 1, 1, 1, 2'd0, 1, 5'd1, 4'h9, 11'd2));
    expect_tx(1, "R6 tx byte");
    rx_beat(8'h99, 1'b0, 1'b1);
    bus_rd(3'd0, d);
    chk("R6 status", d, ctlw(0, 1, 1, 0, 2'd0, 1, 5'd0, 4'h9, 11'd2));
    bus_rd(3'd1, d);
    chk("R6 data kept", d, 32'h11223344);

    // R7 overflow on the twenty-first byte
    bus_wr(3'd0, ctlw(1, 1, 1, 1, 2'd0, 1, 5'd1, 4'h9, 11'd2));
    expect_tx(1, "R7 tx byte");
    for (int j = 0; j < 21; j++) rx_beat(8'(j), 1'b0, 1'b0);
    bus_rd(3'd0, d);
    chk("R7 status", d, ctlw(0, 1, 1, 0, 2'd0, 1, 5'd20, 4'h9, 11'd2));

    // R8 empty reply
    bus_wr(3'd1, 32'h11223344);
    bus_wr(3'd0, ctlw(1, 1, 1, 1, 2'd0, 1, 5'd1, 4'h9, 11'd2));
    expect_tx(1, "R8 tx byte");
    rx_eop_only();
    bus_rd(3'd0, d);
    chk("R8 status", d, ctlw(0, 1, 1, 0, 2'd0, 1, 5'd0, 4'h9, 11'd2));

    // R5 timeout windows (divider 2: one microsecond is four clocks)
    timeout_run(2'd0, 1590, 1615);
    timeout_run(2'd3, 6390, 6415);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule